// File: doc/BRIEF.md
# USB receive packet framer

This block sits between the bit-level receive path of a USB transceiver and the serial interface engine that consumes received packets. The recovery logic upstream hands it decoded bytes with a byte strobe, together with one-cycle indications that a SYNC pattern was found, that an end-of-packet was found, or that a bit-stuffing violation occurred. It also gets a level that reports whether the line is idle. From these inputs the block frames each packet on a parallel handshake of three flags and a data byte. The flags are receive-active for the whole packet, receive-valid for each byte the engine must take, and a one-cycle receive-error.

The block supports high-speed and full-speed operation, selected by `fs_mode`. The two modes differ in four ways: how late receive-active may fall after the line goes idle, how long receive-active must stay low between packets, how a held byte strobe is treated, and what a bit-stuffing violation means. Every byte that follows SYNC is forwarded unchanged, including the packet identifier. The block does not decode or check anything inside the packet.

Top module: `usb_rx_framer`

## Requirements
- R1: While `rst` is high, the next clock edge clears `rx_active`, `rx_valid`, `rx_error` and `rx_data` to zero. A SYNC or byte presented during reset is ignored.
- R2: When the block is waiting for a packet and the inter-packet gap has been met, a clock edge that samples `sync_det` high sets `rx_active` from that edge on.
- R3: In high-speed mode (`fs_mode`=0), while a packet is active, each edge that samples `byte_vld` high sets `rx_valid` for one cycle and presents `byte_in` on `rx_data`. The first byte after SYNC (the PID) is forwarded unchanged. An edge with no byte leaves `rx_valid` low, and `rx_valid` is never high while `rx_active` is low.
- R4: In full-speed mode (`fs_mode`=1), a byte is taken only on an edge where `byte_vld` is high and was low at the previous edge. `rx_valid` is therefore high for exactly one cycle per byte, even when the strobe is held high for several cycles.
- R5: An edge that samples `eop_det` during a packet drops `rx_valid` at once. `rx_active` then falls at the edge that samples `line_idle` high for the N-th consecutive time. N is `HS_DROP` (default 4, legal range 3 to 8) in high-speed mode and `FS_DROP` (default 2, legal range 1 to 2) in full-speed mode. A cycle without idle restarts the count. SYNC and bytes seen during this wait are ignored.
- R6: After `rx_active` falls, a SYNC is accepted only once `rx_active` has been low for at least `HS_GAP` cycles (default 1) in high-speed mode or `FS_GAP` cycles (default 4) in full-speed mode. A SYNC seen earlier is discarded.
- R7: In full-speed mode, an edge that samples `stuff_err` during a packet clears `rx_active` and `rx_valid` and raises `rx_error` for exactly one cycle. `rx_error` is never high together with `rx_active` or `rx_valid`.
- R8: After a full-speed stuffing error, SYNC is ignored until an edge samples `line_idle` high. The gap rule of R6 then applies, counted from the edge where `rx_active` fell.
- R9: In high-speed mode, `stuff_err` during a packet ends the packet exactly like `eop_det` (R5) and never raises `rx_error`.
- R10: Outside a packet, `byte_vld` has no effect: `rx_valid` stays low and `rx_data` keeps its last value.
- R11: When several indications arrive at the same edge, a stuffing error takes precedence over end-of-packet, and end-of-packet takes precedence over a byte. The byte is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| fs_mode | input | 1 | 1 selects full-speed timing, 0 selects high-speed |
| sync_det | input | 1 | SYNC pattern found this cycle |
| eop_det | input | 1 | End-of-packet found this cycle |
| stuff_err | input | 1 | Bit-stuffing violation found this cycle |
| line_idle | input | 1 | Line is in the idle state |
| byte_vld | input | 1 | Decoded byte strobe |
| byte_in | input | DATA_W | Decoded byte |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | `rx_data` holds a byte to take this cycle |
| rx_error | output | 1 | Receive error pulse |
| rx_data | output | DATA_W | Received byte |

## Verification
The bench builds the block with `HS_DROP`=5, `FS_DROP`=2, `HS_GAP`=1 and `FS_GAP`=4. With these values the full-speed drop sits at the top of its legal window. The high-speed gap of one cycle lets a SYNC presented continuously after a packet be accepted on the very first cycle after the drop. The four-cycle full-speed gap gives a span in which back-to-back SYNCs must be discarded. The packets the bench sends include data gaps, idle runs broken by a busy cycle, and held full-speed strobes. They also include colliding indications and aborts on a busy line, so that every state transition is compared against the reference on each clock.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_WAIT,
    ST_STRIP_SYNC,
    ST_DATA,
    ST_DATA_WAIT,
    ST_STRIP_EOP,
    ST_ABORT1,
    ST_ABORT2,
    ST_TERM
  } urx_state_e;

  function automatic int unsigned urx_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/urx_strobe_gate.sv
// Turns the byte strobe into a load enable: level-sensitive in
// high-speed mode, rising-edge-only in full-speed mode.
module urx_strobe_gate (
  input  logic clk,
  input  logic rst,
  input  logic fs_mode,
  input  logic byte_vld,
  output logic load
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= byte_vld;
  end

  assign load = byte_vld & (~fs_mode | ~prev_q);
endmodule

// File: rtl/urx_idle_timer.sv
// Counts consecutive idle samples while enabled; expire fires on the
// edge that sees the LIM-th consecutive idle cycle.
module urx_idle_timer #(
  parameter int unsigned HS_LIM = 4,
  parameter int unsigned FS_LIM = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fs_mode,
  input  logic line_idle,
  output logic expire
);
  localparam int unsigned MAXL = urx_pkg::urx_max(HS_LIM, FS_LIM);
  localparam int unsigned CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] HS_END = CW'(HS_LIM - 1);
  localparam logic [CW-1:0] FS_END = CW'(FS_LIM - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fs_mode ? FS_END : HS_END;
  assign expire = en & line_idle & (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !en || !line_idle || expire) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/urx_gap_timer.sv
// Counts cycles with receive-active low since the last fall and
// reports when the mode's minimum gap has been met.
module urx_gap_timer #(
  parameter int unsigned HS_GAP = 1,
  parameter int unsigned FS_GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic low,
  input  logic fs_mode,
  output logic gap_ok
);
  localparam int unsigned GMAX = urx_pkg::urx_max(HS_GAP, FS_GAP);
  localparam int unsigned CW   = $clog2(GMAX + 1);
  localparam logic [CW-1:0] SAT    = CW'(GMAX);
  localparam logic [CW-1:0] HS_MIN = CW'(HS_GAP - 1);
  localparam logic [CW-1:0] FS_MIN = CW'(FS_GAP - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;

  assign need   = fs_mode ? FS_MIN : HS_MIN;
  assign gap_ok = (cnt_q >= need);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= SAT;
    else if (clr)                 cnt_q <= '0;
    else if (low && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_rx_framer.sv
module usb_rx_framer #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned HS_DROP = 4,
  parameter int unsigned FS_DROP = 2,
  parameter int unsigned HS_GAP  = 1,
  parameter int unsigned FS_GAP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_mode,
  input  logic              sync_det,
  input  logic              eop_det,
  input  logic              stuff_err,
  input  logic              line_idle,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  output logic              rx_active,
  output logic              rx_valid,
  output logic              rx_error,
  output logic [DATA_W-1:0] rx_data
);
  import urx_pkg::*;

  urx_state_e state_q;
  logic       load;
  logic       drop_now;
  logic       gap_ok;
  logic       in_pkt;
  logic       fs_abort;
  logic       fall_evt;

  assign in_pkt   = (state_q == ST_STRIP_SYNC) || (state_q == ST_DATA) ||
                    (state_q == ST_DATA_WAIT);
  assign fs_abort = in_pkt & stuff_err & fs_mode;
  assign fall_evt = fs_abort | drop_now;

  urx_strobe_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .fs_mode  (fs_mode),
    .byte_vld (byte_vld),
    .load     (load)
  );

  urx_idle_timer #(.HS_LIM(HS_DROP), .FS_LIM(FS_DROP)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .en        (state_q == ST_STRIP_EOP),
    .fs_mode   (fs_mode),
    .line_idle (line_idle),
    .expire    (drop_now)
  );

  urx_gap_timer #(.HS_GAP(HS_GAP), .FS_GAP(FS_GAP)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .clr     (fall_evt),
    .low     (~rx_active),
    .fs_mode (fs_mode),
    .gap_ok  (gap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RESET;
      rx_active <= 1'b0;
      rx_valid  <= 1'b0;
      rx_error  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      case (state_q)
        ST_RESET: state_q <= ST_WAIT;
        ST_WAIT, ST_TERM: begin
          if (sync_det && gap_ok) begin
            state_q   <= ST_STRIP_SYNC;
            rx_active <= 1'b1;
          end else if (gap_ok) begin
            state_q <= ST_WAIT;
          end
        end
        ST_STRIP_SYNC, ST_DATA, ST_DATA_WAIT: begin
          if (fs_abort) begin
            state_q   <= ST_ABORT1;
            rx_active <= 1'b0;
            rx_error  <= 1'b1;
          end else if (stuff_err || eop_det) begin
            state_q <= ST_STRIP_EOP;
          end else if (load) begin
            state_q  <= ST_DATA;
            rx_valid <= 1'b1;
            rx_data  <= byte_in;
          end else begin
            state_q <= ST_DATA_WAIT;
          end
        end
        ST_STRIP_EOP: begin
          if (drop_now) begin
            state_q   <= ST_TERM;
            rx_active <= 1'b0;
          end
        end
        ST_ABORT1: state_q <= line_idle ? ST_TERM : ST_ABORT2;
        ST_ABORT2: if (line_idle) state_q <= ST_TERM;
        default:   state_q <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HS_GAP = 1,
  parameter int unsigned FS_GAP = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fs_mode,
  input logic              rx_active,
  input logic              rx_valid,
  input logic              rx_error,
  input logic [DATA_W-1:0] rx_data
);
  localparam int LOW_CAP = 1000;
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)                    low_run <= LOW_CAP;
    else if (rx_active)         low_run <= 0;
    else if (low_run < LOW_CAP) low_run <= low_run + 1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rx_active && !rx_valid && !rx_error && rx_data == '0));

  assert_valid_in_pkt_R3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_active);

  assert_fs_single_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fs_mode) |=> !rx_valid);

  assert_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> (low_run >= (fs_mode ? int'(FS_GAP) : int'(HS_GAP))));

  assert_err_alone_R7: assert property (@(posedge clk) disable iff (rst)
    rx_error |-> (!rx_active && !rx_valid));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rx_error |=> !rx_error);
endmodule

bind usb_rx_framer urx_checker #(.DATA_W(DATA_W), .HS_GAP(HS_GAP), .FS_GAP(FS_GAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fs_mode   (fs_mode),
  .rx_active (rx_active),
  .rx_valid  (rx_valid),
  .rx_error  (rx_error),
  .rx_data   (rx_data)
);

// File: tb/sim_usb_rx_framer.sv
module sim_usb_rx_framer;
  localparam int HS_DROP = 5;
  localparam int FS_DROP = 2;
  localparam int HS_GAP  = 1;
  localparam int FS_GAP  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs_mode = 1'b0;
  logic sync_det = 1'b0, eop_det = 1'b0, stuff_err = 1'b0, line_idle = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic rx_active, rx_valid, rx_error;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  usb_rx_framer #(.DATA_W(8), .HS_DROP(HS_DROP), .FS_DROP(FS_DROP),
                  .HS_GAP(HS_GAP), .FS_GAP(FS_GAP)) u0 (
    .clk(clk), .rst(rst), .fs_mode(fs_mode), .sync_det(sync_det), .eop_det(eop_det),
    .stuff_err(stuff_err), .line_idle(line_idle), .byte_vld(byte_vld), .byte_in(byte_in),
    .rx_active(rx_active), .rx_valid(rx_valid), .rx_error(rx_error), .rx_data(rx_data)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Behavioural reference: 0 waiting, 1 in packet, 2 draining, 3 aborted, 4 reset
  int phase = 4;
  int idle_run = 0;
  int low_run = 1000;
  bit prev_bv = 0;
  bit m_act = 0, m_vld = 0, m_err = 0;
  logic [7:0] m_data = 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      phase = 4; idle_run = 0; low_run = 1000; prev_bv = 0;
      m_act = 0; m_vld = 0; m_err = 0; m_data = 8'h00;
    end else begin
      bit take;
      int need_gap, need_idle;
      take = byte_vld && (!fs_mode || !prev_bv);
      prev_bv = byte_vld;
      need_gap  = fs_mode ? FS_GAP : HS_GAP;
      need_idle = fs_mode ? FS_DROP : HS_DROP;
      m_vld = 0; m_err = 0;
      if (!m_act && low_run < 1000) low_run++;
      if (phase == 4) phase = 0;
      else if (phase == 0) begin
        if (sync_det && low_run >= need_gap) begin m_act = 1; phase = 1; end
      end else if (phase == 1) begin
        if (stuff_err && fs_mode) begin m_act = 0; m_err = 1; phase = 3; low_run = 0; end
        else if (stuff_err || eop_det) begin phase = 2; idle_run = 0; end
        else if (take) begin m_vld = 1; m_data = byte_in; end
      end else if (phase == 2) begin
        if (line_idle) begin
          idle_run++;
          if (idle_run == need_idle) begin m_act = 0; phase = 0; low_run = 0; end
        end else idle_run = 0;
      end else if (phase == 3) begin
        if (line_idle) phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rx_active !== m_act || rx_valid !== m_vld || rx_error !== m_err || rx_data !== m_data) begin
      errors++;
      $display("FAIL %s t=%0t act=%b/%b vld=%b/%b err=%b/%b data=%h/%h (actual/expected)",
               cur_req, $time, rx_active, m_act, rx_valid, m_vld, rx_error, m_err, rx_data, m_data);
    end
  end

  task automatic step(input logic s, input logic e, input logic st, input logic id,
                      input logic bv, input logic [7:0] b);
    @(negedge clk);
    sync_det = s; eop_det = e; stuff_err = st; line_idle = id; byte_vld = bv; byte_in = b;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 8'h00);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with SYNC and byte present
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 8'h55);
    @(negedge clk); rst = 1'b0;
    idle_n(3);

    // R10: bytes outside a packet
    cur_req = "R10";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 8'hAA);
    idle_n(2);

    // R2 / R3: high-speed packet with PID and a data gap
    cur_req = "R2";
    step(1, 0, 0, 0, 0, 8'h00);
    cur_req = "R3";
    step(0, 0, 0, 0, 1, 8'hC3);
    step(0, 0, 0, 0, 1, 8'h11);
    step(0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h22);
    step(0, 0, 0, 0, 1, 8'h33);
    // R5: end of packet, idle run broken once, SYNC/byte ignored while draining
    cur_req = "R5";
    step(0, 1, 0, 0, 0, 8'h00);
    step(1, 0, 0, 1, 1, 8'h99);
    step(0, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 0, 8'h00);
    idle_n(7);

    // R6: high-speed, SYNC held through the drain is taken right after the drop
    cur_req = "R6";
    step(1, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h44);
    step(0, 1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h45);
    step(0, 1, 0, 0, 0, 8'h00);
    idle_n(8);

    // R4: full-speed, strobe held three cycles per byte
    step(0, 0, 0, 1, 0, 8'h00); fs_mode = 1'b1;
    idle_n(6);
    cur_req = "R4";
    step(1, 0, 0, 0, 0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) step(0, 0, 0, 0, 1, 8'(8'hA0 + k));
      for (int j = 0; j < 5; j++) step(0, 0, 0, 0, 0, 8'h00);
    end
    cur_req = "R5";
    step(0, 1, 0, 0, 0, 8'h00);
    idle_n(2);
    // R6: full-speed gap, back-to-back SYNCs
    cur_req = "R6";
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h61);
    step(0, 0, 0, 0, 0, 8'h00);
    // R7: stuffing error with a byte at the same edge
    cur_req = "R7";
    step(0, 0, 1, 0, 1, 8'h77);
    step(0, 0, 0, 0, 0, 8'h00);
    // R8: SYNC ignored on busy line, then gap after idle
    cur_req = "R8";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 1, 0, 8'h00);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h62);
    step(0, 0, 0, 0, 0, 8'h00);
    // R11: full-speed stuffing error beats end-of-packet and byte
    cur_req = "R11";
    step(0, 1, 1, 0, 1, 8'h5A);
    idle_n(8);

    // R11: high-speed end-of-packet beats byte
    step(0, 0, 0, 1, 0, 8'h00); fs_mode = 1'b0;
    idle_n(4);
    step(1, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h6A);
    step(0, 1, 0, 0, 1, 8'h6B);
    idle_n(8);

    // R9: high-speed stuffing error ends packet without error flag
    cur_req = "R9";
    step(1, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 1, 8'h7C);
    step(0, 0, 1, 0, 1, 8'h7D);
    step(0, 0, 0, 0, 0, 8'h00);
    idle_n(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule